// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit down-counter fed by a free-running 7-bit prescaler, reached through three byte-wide registers on a simple synchronous bus. A byte write takes effect at the next clock edge. A read is combinational from the register address.

The control register starts the prescaler and picks one of eight division ratios, from 1 to 128. Each selected prescaler period takes one count off the timer. When the timer wraps from 00h to FFh it sets a sticky zero flag. That flag can raise an interrupt request. In output mode it also copies a programmable data bit to the timer pin, which is driven as push-pull.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the prescaler register (address 0) reads 7Fh, the counter register (address 1) reads FFh and the control register (address 2) reads 00h. While reset is held, `irq`, `pin_oe` and `pin_out` are 0.
- R2: Bit 7 of the prescaler register always reads 0. A bus write to address 0 while counting is enabled loads `wdata[6:0]` into the prescaler in place of that cycle's decrement.
- R3: While the run bit (control bit 3) is 0, the prescaler is forced to 7Fh and the counter does not decrement.
- R4: While the run bit is 1 and no prescaler write occurs, the prescaler decreases by 1 on each clock and wraps from 00h to 7Fh.
- R5: The divide select (control bits 2:0, value k) makes the counter decrement once every 2^k clocks. For k=0 this is every enabled clock. For k>0 it is the clock on which prescaler bit k-1 goes from 1 to 0.
- R6: A bus write to address 1 loads the counter with `wdata` and overrides any decrement in the same cycle.
- R7: A decrement from 00h to FFh sets the zero flag (control bit 7), even if the same cycle carries a control write. Otherwise the flag keeps its value until a control write replaces it with `wdata[7]`.
- R8: `irq` is 1 exactly when both the interrupt enable (control bit 6) and the zero flag are 1.
- R9: `pin_oe` follows the pin direction bit (control bit 5): 0 means input mode and 1 means push-pull output.
- R10: On a wrap while the pin direction bit is 1, `pin_out` takes the value of the pin data bit (control bit 4). At all other times `pin_out` holds its value.
- R11: A control write stores `wdata[6:0]` in control bits 6:0, and all eight control bits read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 prescaler, 1 counter, 2 control |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| pin_oe | output | 1 | Timer pin output enable |
| pin_out | output | 1 | Timer pin output data |

## Verification
The assertions assume that `wdata` is defined whenever `wr_en` is 1, and that `rst_n` is low on the first clock. The bench drives every input to a known value from time zero and holds reset for several cycles before it releases it. Stimulus changes only on falling edges. Write data and addresses are drawn at random, including address 3, which decodes to nothing. This steers the random traffic through wraps that collide with control writes and through changes of the divide select in the middle of a prescaler period.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int PW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          pin_oe,
  output logic          pin_out
);
  localparam logic [PW-1:0] PS_INIT = {PW{1'b1}};
  localparam logic [CW-1:0] CNT_INIT = {CW{1'b1}};

  logic [PW-1:0] psc;
  logic [CW-1:0] cnt;
  logic          zf, ien, pdir, pdat, run;
  logic [2:0]    div;
  logic [PW:0]   span, half, mask;
  logic          tick, wrap;
  logic          wr_psc, wr_cnt, wr_ctl;

  assign wr_psc = wr_en && addr == 2'd0;
  assign wr_cnt = wr_en && addr == 2'd1;
  assign wr_ctl = wr_en && addr == 2'd2;

  assign span = (PW+1)'(1) << div;
  assign half = span >> 1;
  assign mask = span - 1'b1;
  assign tick = run && (({1'b0, psc} & mask) == half);
  assign wrap = tick && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc <= PS_INIT;
      cnt <= CNT_INIT;
      zf <= 1'b0;
      {ien, pdir, pdat, run, div} <= '0;
      pin_out <= 1'b0;
    end else begin
      if (!run)        psc <= PS_INIT;
      else if (wr_psc) psc <= wdata[PW-1:0];
      else             psc <= psc - 1'b1;

      if (wr_cnt)    cnt <= wdata[CW-1:0];
      else if (tick) cnt <= cnt - 1'b1;

      zf <= (wr_ctl ? wdata[7] : zf) | wrap;
      if (wr_ctl) {ien, pdir, pdat, run, div} <= wdata[6:0];

      if (wrap && pdir) pin_out <= pdat;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = 8'({1'b0, psc});
      2'd1:    rdata = 8'(cnt);
      2'd2:    rdata = {zf, ien, pdir, pdat, run, div};
      default: rdata = 8'h00;
    endcase
  end

  assign irq = ien & zf;
  assign pin_oe = pdir;

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> psc == PS_INIT);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wr_psc |=> psc == $past(psc) - 1'b1);
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wdata[CW-1:0]));
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_cnt |=> $stable(cnt));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> zf);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zf && !wr_ctl |=> zf);
  assert_pinhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap && pdir) |=> $stable(pin_out));
endmodule

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, pin_oe, pin_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prescaled_timer dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .pin_oe(pin_oe), .pin_out(pin_out));

  int m_psc, m_cnt, m_ctl, m_pin;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 127; m_cnt = 255; m_ctl = 0; m_pin = 0;
    end else begin
      int k, run, tk, uf, npsc, ncnt, nctl;
      k = m_ctl % 8;
      run = (m_ctl / 8) % 2;
      if (k == 0) tk = 1;
      else tk = ((m_psc / (2 ** (k-1))) % 2 == 1) && (m_psc % (2 ** (k-1)) == 0);
      tk = tk && run;
      uf = tk && m_cnt == 0;
      if (!run) npsc = 127;
      else if (wr_en && addr == 0) npsc = wdata % 128;
      else npsc = (m_psc + 127) % 128;
      if (wr_en && addr == 1) ncnt = wdata;
      else if (tk) ncnt = (m_cnt + 255) % 256;
      else ncnt = m_cnt;
      nctl = (wr_en && addr == 2) ? wdata : m_ctl;
      if (uf) nctl = nctl | 128;
      if (uf && (m_ctl / 32) % 2 == 1) m_pin = (m_ctl / 16) % 2;
      m_psc = npsc; m_cnt = ncnt; m_ctl = nctl;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int exp;
    case (addr)
      2'd0: exp = m_psc;
      2'd1: exp = m_cnt;
      2'd2: exp = m_ctl;
      default: exp = 0;
    endcase
    chk(rdata == exp, addr == 0 ? "R2/R4/R5" : addr == 1 ? "R5/R6" : "R7/R11", rdata, exp);
    chk(irq == ((m_ctl / 64) % 2 && m_ctl / 128), "R8", irq, (m_ctl / 64) % 2 && m_ctl / 128);
    chk(pin_oe == (m_ctl / 32) % 2, "R9", pin_oe, (m_ctl / 32) % 2);
    chk(pin_out == m_pin, "R10", pin_out, m_pin);
  endtask

  task automatic step(input bit w, input int a, input int d);
    wr_en = w; addr = 2'(a); wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input int a);
    step(0, a, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(irq == 0 && pin_oe == 0 && pin_out == 0, "R1", {irq, pin_oe, pin_out}, 0);
    rst_n = 1'b1;
    rd(0); chk(rdata == 8'h7f, "R1", rdata, 8'h7f);
    rd(1); chk(rdata == 8'hff, "R1", rdata, 8'hff);
    rd(2); chk(rdata == 8'h00, "R1", rdata, 8'h00);
    for (int i = 0; i < 20; i++) rd(i % 2);
    chk(rdata == 8'hff, "R3 counter frozen", rdata, 8'hff);
    for (int k = 0; k < 8; k++) begin
      step(1, 1, 3);
      step(1, 2, 8'h78 | k);
      for (int i = 0; i < 5 * (2 ** k); i++) rd(i % 3);
      step(1, 2, 8'h30 | k);
      for (int i = 0; i < 5 * (2 ** k); i++) rd(i % 3);
    end
    step(1, 2, 8'h08);
    step(1, 0, 8'hff);
    rd(0); chk(rdata[7] == 0, "R2 bit7 reads zero", rdata, 0);
    step(1, 1, 0);
    step(1, 2, 8'h68);
    rd(2); chk(rdata[7] == 1, "R7 wrap beats clear", rdata, 8'he8);
    step(1, 2, 8'h00);
    rd(2); chk(rdata == 0, "R7 clear", rdata, 0);
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) step(1, $urandom % 4, $urandom % 256);
      else if (r == 1) step(1, 1, $urandom % 4);
      else rd($urandom % 4);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule